// File: doc/BRIEF.md
# CTS-Gated Serial Character Transmitter

This block turns bytes into asynchronous serial frames on one output line. The line rests high. Each frame is a low start bit, then the data bits with the least significant bit first, then an optional even-parity bit, then one or two high stop bits. Bit timing comes from an enable pulse, `bit_tick`, that is made outside the block. Each bit lasts exactly one tick period, and a frame always begins on a tick.

Software-side control arrives as single-cycle task pulses: start, stop and suspend. Data arrives one byte at a time through a write strobe into a one-entry holding register. `tx_ready` pulses once for each frame that is fully sent.

When flow control is on, an active-low clear-to-send input stops new frames from starting. A frame already on the line is never cut short by it. A stop task cuts off output at once and drops any held byte. A suspend task lets the frame in flight finish and then parks the transmitter until the next start task.

Top module: `uart_cts_tx`

## Requirements
- R1: After reset `txd` is 1 and `tx_ready` is 0, and `txd` stays 1 whenever no frame is being sent.
- R2: A frame starts on a clock where `bit_tick` is 1. It sends a 0 start bit, then the 8 data bits least significant first, and each bit holds for one tick period.
- R3: With `cfg_parity_en`=1, one extra bit follows the data bits. Its value is the XOR of the data bits, so the count of ones over data plus parity is even. With `cfg_parity_en`=0 no such bit is sent.
- R4: The frame ends with one high stop bit when `cfg_two_stop`=0 and with two when it is 1.
- R5: No frame starts before a start task. A byte written earlier is held and sent after the start task.
- R6: `tx_ready` is a one-cycle pulse, given once per completed frame, on the clock where the last stop bit ends.
- R7: With `cfg_flow_en`=1 and `cts_n`=1, no new frame starts. A frame already started when `cts_n` rises still completes in full.
- R8: With `cfg_flow_en`=0 the value of `cts_n` has no effect.
- R9: A stop task drives `txd` to 1 on the next clock and discards the held byte. An aborted frame gives no `tx_ready`.
- R10: A suspend task lets the frame in flight complete with its `tx_ready`. After that no frame starts until the next start task.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle bit-rate enable |
| task_start | input | 1 | Start/resume transmitter pulse |
| task_stop | input | 1 | Immediate stop pulse |
| task_suspend | input | 1 | Suspend-after-frame pulse |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Byte to send |
| cfg_parity_en | input | 1 | Append even parity bit |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cfg_flow_en | input | 1 | Honour `cts_n` |
| cts_n | input | 1 | Clear to send, active low |
| txd | output | 1 | Serial output, idle high |
| tx_ready | output | 1 | Frame-complete pulse |

## Verification
The frame shape is exercised with the all-zero and all-one bytes and with alternating patterns. These show up a swapped bit order or a stuck data bit. The patterns are sent both with the plain one-stop format and with parity and two stop bits, so a parity bit in the wrong place or an odd-parity result stands out from a correct frame. Flow control is tried three ways: clear-to-send held inactive before a write, clear-to-send dropped in mid-frame, and flow control disabled while the input is inactive. Together these separate gating at frame boundaries from wrongly cutting a frame or wrongly ignoring the input. Stop and suspend are each issued in mid-frame, which tells an immediate abort apart from a deferred halt.

// File: rtl/uctx_pkg.sv
package uctx_pkg;
   // Static frame options sampled when a frame is launched
   typedef struct packed {
      logic par_en;
      logic two_stop;
   } uctx_fmt_t;

   function automatic int unsigned frame_max(input int unsigned dw);
      return dw + 4;   // start + data + parity + two stops
   endfunction
endpackage

// File: rtl/uctx_cts_sync.sv
module uctx_cts_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cts_n,
   output logic cts_n_s
);
   generate
      if (STAGES == 0) begin : g_pass
         assign cts_n_s = cts_n;
      end else begin : g_sync
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= '1;
            end else begin
               chain[0] <= cts_n;
               for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            end
         end
         assign cts_n_s = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/uctx_hold.sv
module uctx_hold #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   input  logic              flush,
   output logic              hold_valid,
   output logic [DATA_W-1:0] hold_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_valid <= 1'b0;
         hold_data  <= '0;
      end else if (flush) begin
         hold_valid <= 1'b0;
      end else if (wr_en) begin
         hold_valid <= 1'b1;
         hold_data  <= wr_data;
      end else if (take) begin
         hold_valid <= 1'b0;
      end
   end

   // R9
   flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !hold_valid);
endmodule

// File: rtl/uctx_ctrl.sv
module uctx_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic task_start,
   input  logic task_stop,
   input  logic task_suspend,
   input  logic frame_busy,
   input  logic frame_done,
   output logic run,
   output logic launch_ok
);
   logic susp_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run       <= 1'b0;
         susp_pend <= 1'b0;
      end else begin
         if (task_stop) begin
            run       <= 1'b0;
            susp_pend <= 1'b0;
         end else if (task_start) begin
            run       <= 1'b1;
            susp_pend <= 1'b0;
         end else if (task_suspend) begin
            if (frame_busy) susp_pend <= 1'b1;
            else            run       <= 1'b0;
         end else if (susp_pend && frame_done) begin
            run       <= 1'b0;
            susp_pend <= 1'b0;
         end
      end
   end

   assign launch_ok = run && !susp_pend;

   // R10
   susp_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (susp_pend && !task_start && !task_stop) |-> !launch_ok);
endmodule

// File: rtl/uctx_frame.sv
module uctx_frame
   import uctx_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              launch_req,
   input  logic              abort,
   input  logic [DATA_W-1:0] data,
   input  uctx_fmt_t         fmt,
   output logic              take,
   output logic              busy,
   output logic              done,
   output logic              txd
);
   localparam int unsigned FRAME_MAX = frame_max(DATA_W);
   localparam int unsigned CNT_W     = $clog2(FRAME_MAX + 1);

   logic [FRAME_MAX-1:0] img, shift;
   logic [CNT_W-1:0]     nbits, left;

   always_comb begin
      img           = '1;
      img[0]        = 1'b0;
      img[DATA_W:1] = data;
      if (fmt.par_en) img[DATA_W+1] = ^data;
      nbits = CNT_W'(DATA_W + 2) + CNT_W'(fmt.par_en) + CNT_W'(fmt.two_stop);
   end

   assign take = launch_req && bit_tick && !busy && !abort;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         txd   <= 1'b1;
         shift <= '1;
         left  <= '0;
      end else begin
         done <= 1'b0;
         if (abort) begin
            busy <= 1'b0;
            txd  <= 1'b1;
            left <= '0;
         end else if (take) begin
            busy  <= 1'b1;
            txd   <= img[0];
            shift <= img >> 1;
            left  <= nbits - CNT_W'(1);
         end else if (busy && bit_tick) begin
            if (left == '0) begin
               busy <= 1'b0;
               done <= 1'b1;
               txd  <= 1'b1;
            end else begin
               txd   <= shift[0];
               shift <= {1'b1, shift[FRAME_MAX-1:1]};
               left  <= left - CNT_W'(1);
            end
         end
      end
   end

   // R6
   ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R6
   ready_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(txd) && txd));
   // R9
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (txd && !busy && !done));
   // R1
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !take) |=> txd);
endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx
   import uctx_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned CTS_SYNC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              task_start,
   input  logic              task_stop,
   input  logic              task_suspend,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              cfg_parity_en,
   input  logic              cfg_two_stop,
   input  logic              cfg_flow_en,
   input  logic              cts_n,
   output logic              txd,
   output logic              tx_ready
);
   generate
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
         $error("uart_cts_tx: DATA_W must be 5..9");
      end
      if (CTS_SYNC > 4) begin : g_bad_sync
         $error("uart_cts_tx: CTS_SYNC must be 0..4");
      end
   endgenerate

   logic              cts_n_s, cts_ok;
   logic              hold_valid, take, busy, run, launch_ok, launch_req;
   logic [DATA_W-1:0] hold_data;
   uctx_fmt_t         fmt;

   assign fmt.par_en   = cfg_parity_en;
   assign fmt.two_stop = cfg_two_stop;

   uctx_cts_sync #(.STAGES(CTS_SYNC)) u_sync (
      .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .cts_n_s(cts_n_s));

   assign cts_ok     = !cfg_flow_en || !cts_n_s;
   assign launch_req = launch_ok && hold_valid && cts_ok;

   uctx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .take(take), .flush(task_stop),
      .hold_valid(hold_valid), .hold_data(hold_data));

   uctx_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .task_start(task_start), .task_stop(task_stop),
      .task_suspend(task_suspend), .frame_busy(busy), .frame_done(tx_ready),
      .run(run), .launch_ok(launch_ok));

   uctx_frame #(.DATA_W(DATA_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .launch_req(launch_req),
      .abort(task_stop), .data(hold_data), .fmt(fmt), .take(take),
      .busy(busy), .done(tx_ready), .txd(txd));

   // R7
   cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_flow_en && cts_n_s && !busy) |=> !busy);
   // R5
   no_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !busy) |=> !busy);
endmodule

// File: tb/tb_uart_cts_tx.sv
`timescale 1ns/1ps
module tb_uart_cts_tx;
   localparam int TICK_DIV = 8;

   logic clk = 1'b0, rst_n = 1'b0, bit_tick = 1'b0;
   logic task_start = 0, task_stop = 0, task_suspend = 0, wr_en = 0;
   logic [7:0] wr_data = '0;
   logic cfg_parity_en = 0, cfg_two_stop = 0, cfg_flow_en = 0, cts_n = 0;
   logic txd, tx_ready;

   always #10 clk = ~clk;

   uart_cts_tx dut (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .task_start(task_start),
      .task_stop(task_stop), .task_suspend(task_suspend), .wr_en(wr_en),
      .wr_data(wr_data), .cfg_parity_en(cfg_parity_en), .cfg_two_stop(cfg_two_stop),
      .cfg_flow_en(cfg_flow_en), .cts_n(cts_n), .txd(txd), .tx_ready(tx_ready));

   int n_cmp = 0, n_bad = 0, ready_cnt = 0, good_frames = 0;
   bit mon_en = 1'b1, done_flag = 1'b0;
   logic [9:0] exp_q[$];  // {parity_en, two_stop, data}

   int tick_ctr = 0;
   always @(negedge clk) begin
      tick_ctr = (tick_ctr == TICK_DIV-1) ? 0 : tick_ctr + 1;
      bit_tick <= (tick_ctr == TICK_DIV-1);
   end

   always @(negedge clk) if (rst_n && tx_ready) ready_cnt++;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Monitor: decode each frame mid-bit and compare against the queue
   logic [9:0] m_item;
   logic [7:0] m_data;
   logic       m_par, m_bad_stop, m_start;
   bit         m_have;
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && mon_en && txd == 1'b0) begin
            m_have = exp_q.size() > 0;
            m_item = m_have ? exp_q.pop_front() : 10'h0;
            repeat (TICK_DIV/2) @(negedge clk);
            m_start = txd;
            for (int i = 0; i < 8; i++) begin
               repeat (TICK_DIV) @(negedge clk);
               m_data[i] = txd;
            end
            m_par = 1'b0;
            if (m_item[9]) begin
               repeat (TICK_DIV) @(negedge clk);
               m_par = txd;
            end
            m_bad_stop = 1'b0;
            for (int s = 0; s < (m_item[8] ? 2 : 1); s++) begin
               repeat (TICK_DIV) @(negedge clk);
               if (txd !== 1'b1) m_bad_stop = 1'b1;
            end
            if (mon_en) begin
               chk(m_have, "R5 unexpected frame", 1, 0);
               chk(m_start == 1'b0, "R2 start bit", m_start, 0);
               // R2 data order, LSB first
               chk(m_data == m_item[7:0], "R2 data", m_data, m_item[7:0]);
               // R3 even parity
               if (m_item[9]) chk(m_par == ^m_item[7:0], "R3 parity", m_par, ^m_item[7:0]);
               // R4 stop bits
               chk(!m_bad_stop, "R4 stop bits", m_bad_stop, 0);
               good_frames++;
            end
         end
      end
   end

   task automatic pulse_start();
      @(negedge clk); task_start = 1; @(negedge clk); task_start = 0;
   endtask
   task automatic pulse_stop();
      @(negedge clk); task_stop = 1; @(negedge clk); task_stop = 0;
   endtask
   task automatic pulse_susp();
      @(negedge clk); task_suspend = 1; @(negedge clk); task_suspend = 0;
   endtask

   // Driver: write a byte and record what must appear on the line
   task automatic send(input logic [7:0] d, input bit expect_it);
      @(negedge clk);
      wr_en = 1; wr_data = d;
      if (expect_it) exp_q.push_back({cfg_parity_en, cfg_two_stop, d});
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic wait_ready(input string tag);
      bit seen = 0;
      for (int k = 0; k < 3000 && !seen; k++) begin
         @(negedge clk);
         if (tx_ready) seen = 1;
      end
      chk(seen, tag, seen, 1);
      @(negedge clk);
      // R6 single-cycle pulse
      chk(tx_ready == 1'b0, "R6 ready width", tx_ready, 0);
      repeat (TICK_DIV) @(negedge clk);
   endtask

   task automatic idle_watch(input int n, input string tag);
      bit ok = 1;
      repeat (n) begin
         @(negedge clk);
         if (txd !== 1'b1) ok = 0;
      end
      chk(ok, tag, txd, 1);
   endtask

   task automatic wait_start_bit();
      for (int k = 0; k < 3000; k++) begin
         @(negedge clk);
         if (txd == 1'b0) break;
      end
   endtask

   int rc_before;

   initial begin
      #200000000;
      if (!done_flag) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(txd == 1'b1, "R1 reset txd", txd, 1);
      chk(tx_ready == 1'b0, "R1 reset ready", tx_ready, 0);
      rst_n = 1;
      repeat (4) @(negedge clk);

      // R5 byte held before start
      send(8'h5A, 1);
      idle_watch(200, "R5 held before start");
      pulse_start();
      wait_ready("R5 sent after start");

      // R2 patterns, plain format
      send(8'h00, 1); wait_ready("R2 ready 00");
      send(8'hFF, 1); wait_ready("R2 ready FF");
      send(8'hA5, 1); wait_ready("R2 ready A5");
      idle_watch(40, "R1 idle between frames");

      // R3 R4 parity and two stop bits
      cfg_parity_en = 1; cfg_two_stop = 1;
      send(8'h01, 1); wait_ready("R3 ready 01");
      send(8'h7E, 1); wait_ready("R4 ready 7E");
      cfg_two_stop = 0;
      send(8'hC3, 1); wait_ready("R3 ready C3");
      cfg_parity_en = 0;
      // R6 one pulse per frame
      chk(ready_cnt == good_frames, "R6 ready count", ready_cnt, good_frames);

      // R7 CTS inactive blocks new frame
      cfg_flow_en = 1; cts_n = 1;
      repeat (6) @(negedge clk);
      send(8'h3C, 1);
      idle_watch(200, "R7 cts blocks");
      cts_n = 0;
      wait_ready("R7 sent after cts");
      // R7 CTS drop mid-frame: frame completes
      send(8'h96, 1);
      wait_start_bit();
      cts_n = 1;
      wait_ready("R7 frame completes");
      send(8'h69, 1);
      idle_watch(200, "R7 paused at boundary");
      cts_n = 0;
      wait_ready("R7 resumed");

      // R8 flow off ignores cts
      cfg_flow_en = 0; cts_n = 1;
      repeat (6) @(negedge clk);
      send(8'h11, 1); wait_ready("R8 cts ignored");
      cts_n = 0;

      // R9 stop mid-frame
      send(8'hF0, 1);
      wait_start_bit();
      repeat (3*TICK_DIV) @(negedge clk);
      mon_en = 0;
      rc_before = ready_cnt;
      @(negedge clk); task_stop = 1;
      @(negedge clk); task_stop = 0;
      chk(txd == 1'b1, "R9 line high after stop", txd, 1);
      idle_watch(300, "R9 stays idle");
      chk(ready_cnt == rc_before, "R9 no ready on abort", ready_cnt, rc_before);
      mon_en = 1;
      // R9 held byte discarded
      send(8'h77, 0);
      pulse_stop();
      pulse_start();
      idle_watch(300, "R9 held byte dropped");

      // R10 suspend mid-frame
      send(8'h2D, 1);
      wait_start_bit();
      pulse_susp();
      wait_ready("R10 frame completes");
      send(8'h4B, 1);
      idle_watch(300, "R10 parked");
      pulse_start();
      wait_ready("R10 resumed");

      repeat (40) @(negedge clk);
      chk(exp_q.size() == 0, "R2 all frames seen", exp_q.size(), 0);
      chk(ready_cnt == good_frames, "R6 final ready count", ready_cnt, good_frames);

      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule